// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is a serial peripheral master that software drives through a small 32-bit register window. Software programs a mode word (enable, master select, character length, clock prescaler, bit order, loopback), then writes one character into the transmit register. The controller moves that character into its shift engine, and produces a serial clock that idles low. It drives the outgoing data line so that each bit is valid before the clock rises, and it samples the incoming line on each rising edge (SPI mode 0). When the last bit is in, the received character is placed right-justified in the receive register and a "receive ready" event is raised.

Two sticky event flags report progress: one for a received character waiting, one for the transmit register being free. Both are cleared by writing ones to them. An interrupt line is the OR of the events gated by a mask register. Chip-select is driven by surrounding board logic and is not part of the block.

The shift engine is a four-state machine. IDLE waits for a held character; IDLE to SETUP loads it (a "take"). SETUP holds the clock low for one half-period with the current bit on the data line; SETUP to HIGH is the rising edge where the input is sampled. HIGH holds the clock high; HIGH to SETUP is the falling edge that advances to the next bit, while HIGH to DONE happens after the last bit. DONE latches the received word and always returns to IDLE.

Top module: `spim_ctrl`

## Requirements
- R1: After reset the mode register (offset 0x20) reads 0, the event register (0x24) reads 0x0000_0100 (free flag set, ready flag clear), the command register (0x2C) reads 0, the clock output is low and the interrupt is low.
- R2: A write to the transmit register (0x30) starts an exchange only when mode bit 24 (enable) and bit 25 (master) are both set; otherwise it is ignored, no clock pulse appears and the events are unchanged.
- R3: Mode bits 23:20 set the character length: 0 gives 32 bits, 1 to 3 give 4 bits, N from 4 to 15 gives N+1 bits; an exchange produces exactly that many clock pulses.
- R4: Mode bits 19:16 hold a prescaler P; the clock period is 4*(P+1) system clocks (P=1 gives one eighth of the system clock), the clock idles low and incoming data is sampled on its rising edge.
- R5: With mode bit 26 set the character leaves most significant bit (bit length-1) first; with it clear bit 0 leaves first; the received bits are placed in the same order.
- R6: Characters are right-justified: bits of the transmit word above the length are never sent, and the receive register (0x34) reads zero above the length.
- R7: With mode bit 30 set the outgoing stream is fed back into the receiver and the external input pin is ignored.
- R8: Event bit 9 sets when a received character is placed in the receive register; event bit 8 clears on an accepted transmit write and sets when that character moves into the shift engine.
- R9: A transmit write accepted while an exchange runs is held and sent after it; a further transmit write while a character is already held is dropped.
- R10: Writing the event register clears each flag whose written bit is 1 and leaves flags written with 0 untouched.
- R11: The interrupt equals the OR of (event AND mask), with the mask register at 0x28 using bits 9 and 8; a zero mask keeps it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset in the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| irq | output | 1 | Masked event interrupt |

## Verification
The main exchange is tried with a table of characters that differ in length code (4, 5, 8, 16, 32 bits and an out-of-range low code), bit order, prescaler and loopback. In each case the received word, the count of clock pulses, the bit sequence seen on the data line and the clock period are compared. External-input cases use a bit pattern different from the transmitted one, so a receiver wired to the wrong source or the wrong bit slot shows up. Loopback cases drive the inverse of the character on the input pin, which exposes a receiver that still listens to the pin. Short lengths with ones in the high transmit bits separate correct length decoding from a shifter that sends the whole word.

// File: rtl/spim_pkg.sv
package spim_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_HIGH  = 2'd2,
        ST_DONE  = 2'd3
    } spim_state_e;

    // Register offsets within the window
    localparam logic [7:0] OFS_MODE  = 8'h20;
    localparam logic [7:0] OFS_EVENT = 8'h24;
    localparam logic [7:0] OFS_MASK  = 8'h28;
    localparam logic [7:0] OFS_CMD   = 8'h2C;
    localparam logic [7:0] OFS_TX    = 8'h30;
    localparam logic [7:0] OFS_RX    = 8'h34;

    // Mode word bit positions
    localparam int MB_LOOP = 30;
    localparam int MB_REV  = 26;
    localparam int MB_MSTR = 25;
    localparam int MB_EN   = 24;
    localparam int MB_LEN  = 20;
    localparam int MB_PRE  = 16;

    // Event / mask bit positions
    localparam int EV_RDY  = 9;
    localparam int EV_FREE = 8;

    localparam logic [31:0] MODE_WMASK = 32'h470F_0000 | 32'h00F0_0000;

    // Length code to (length - 1)
    function automatic logic [4:0] len_code_to_m1(input logic [3:0] code);
        logic [4:0] r;
        if (code == 4'd0)
            r = 5'd31;
        else if (code < 4'd4)
            r = 5'd3;
        else
            r = {1'b0, code};
        return r;
    endfunction

endpackage

// File: rtl/spim_regs.sv
module spim_regs
    import spim_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int PRE_W  = 4,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cfg_en,
    output logic              cfg_mstr,
    output logic              cfg_loop,
    output logic              cfg_rev,
    output logic [LEN_W-1:0]  cfg_len,
    output logic [PRE_W-1:0]  cfg_pre,
    output logic [DATA_W-1:0] tx_word,
    output logic              tx_full,
    input  logic              take,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_word,
    output logic              ev_rdy,
    output logic              ev_free,
    output logic [1:0]        mask_bits,
    output logic              irq
);

    logic [DATA_W-1:0] mode_q;
    logic [DATA_W-1:0] rx_q;
    logic              wr_mode, wr_event, wr_mask, wr_tx, tx_accept;

    assign wr_mode   = bus_sel && bus_wr && (bus_addr == OFS_MODE);
    assign wr_event  = bus_sel && bus_wr && (bus_addr == OFS_EVENT);
    assign wr_mask   = bus_sel && bus_wr && (bus_addr == OFS_MASK);
    assign wr_tx     = bus_sel && bus_wr && (bus_addr == OFS_TX);
    assign tx_accept = wr_tx && cfg_en && cfg_mstr && !tx_full;

    assign cfg_en   = mode_q[MB_EN];
    assign cfg_mstr = mode_q[MB_MSTR];
    assign cfg_loop = mode_q[MB_LOOP];
    assign cfg_rev  = mode_q[MB_REV];
    assign cfg_len  = mode_q[MB_LEN +: LEN_W];
    assign cfg_pre  = mode_q[MB_PRE +: PRE_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= '0;
            mask_bits <= '0;
        end else begin
            if (wr_mode) mode_q <= bus_wdata & MODE_WMASK;
            if (wr_mask) mask_bits <= {bus_wdata[EV_RDY], bus_wdata[EV_FREE]};
        end
    end

    // Transmit holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_word <= '0;
            tx_full <= 1'b0;
        end else if (tx_accept) begin
            tx_word <= bus_wdata;
            tx_full <= 1'b1;
        end else if (take) begin
            tx_full <= 1'b0;
        end
    end

    // Receive register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rx_q <= '0;
        else if (rx_done)
            rx_q <= rx_word;
    end

    // Sticky events: hardware set wins over write-one-to-clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_rdy  <= 1'b0;
            ev_free <= 1'b1;
        end else begin
            if (rx_done)
                ev_rdy <= 1'b1;
            else if (wr_event && bus_wdata[EV_RDY])
                ev_rdy <= 1'b0;

            if (take)
                ev_free <= 1'b1;
            else if (tx_accept || (wr_event && bus_wdata[EV_FREE]))
                ev_free <= 1'b0;
        end
    end

    assign irq = |({ev_rdy, ev_free} & mask_bits);

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (bus_addr)
                OFS_MODE:  bus_rdata = mode_q;
                OFS_EVENT: begin
                    bus_rdata[EV_RDY]  = ev_rdy;
                    bus_rdata[EV_FREE] = ev_free;
                end
                OFS_MASK: begin
                    bus_rdata[EV_RDY]  = mask_bits[1];
                    bus_rdata[EV_FREE] = mask_bits[0];
                end
                OFS_TX:    bus_rdata = tx_word;
                OFS_RX:    bus_rdata = rx_q;
                default:   bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/spim_clkdiv.sv
module spim_clkdiv #(
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] pre,
    output logic             tick
);

    localparam int CNT_W = PRE_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] half_m1;

    // Half period = 2*(pre+1) cycles, so terminal count = 2*pre+1
    assign half_m1 = {pre, 1'b1};
    assign tick    = run && (cnt_q == half_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_full,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              cfg_rev,
    input  logic              cfg_loop,
    input  logic [IDX_W-1:0]  cfg_len_m1,
    input  logic              tick,
    input  logic              miso,
    output logic              take,
    output logic              done,
    output logic              busy,
    output logic              run,
    output logic [DATA_W-1:0] rx_word,
    output logic              sck,
    output logic              mosi
);

    spim_state_e       state_q, state_d;
    logic [IDX_W-1:0]  bit_q, lenm1_q, pos;
    logic              rev_q, loop_q, tx_bit, rx_bit;
    logic [DATA_W-1:0] txsh_q, rxsh_q;

    assign pos    = rev_q ? (lenm1_q - bit_q) : bit_q;
    assign tx_bit = txsh_q[pos];
    assign rx_bit = loop_q ? tx_bit : miso;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (tx_full) state_d = ST_SETUP;
            ST_SETUP: if (tick)    state_d = ST_HIGH;
            ST_HIGH:  if (tick)    state_d = (bit_q == lenm1_q) ? ST_DONE : ST_SETUP;
            ST_DONE:               state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q   <= '0;
            lenm1_q <= '0;
            rev_q   <= 1'b0;
            loop_q  <= 1'b0;
            txsh_q  <= '0;
            rxsh_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (tx_full) begin
                    bit_q   <= '0;
                    lenm1_q <= cfg_len_m1;
                    rev_q   <= cfg_rev;
                    loop_q  <= cfg_loop;
                    txsh_q  <= tx_word;
                    rxsh_q  <= '0;
                end
                ST_SETUP: if (tick) rxsh_q[pos] <= rx_bit;
                ST_HIGH:  if (tick && (bit_q != lenm1_q)) bit_q <= bit_q + 1'b1;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        take    = (state_q == ST_IDLE) && tx_full;
        done    = (state_q == ST_DONE);
        busy    = (state_q != ST_IDLE);
        run     = (state_q == ST_SETUP) || (state_q == ST_HIGH);
        sck     = (state_q == ST_HIGH);
        mosi    = run ? tx_bit : 1'b0;
        rx_word = rxsh_q;
    end

endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
    import spim_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int PRE_W  = 4,
    parameter int LEN_W  = 4,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              irq
);

    logic              cfg_en, cfg_mstr, cfg_loop, cfg_rev;
    logic [LEN_W-1:0]  cfg_len;
    logic [PRE_W-1:0]  cfg_pre;
    logic [DATA_W-1:0] tx_word, rx_word;
    logic              tx_full, eng_take, eng_done, eng_busy, eng_run, tick;
    logic              ev_rdy, ev_free;
    logic [1:0]        mask_bits;
    logic [4:0]        len_m1_full;
    logic [IDX_W-1:0]  len_m1;

    assign len_m1_full = len_code_to_m1(cfg_len);
    assign len_m1      = len_m1_full[IDX_W-1:0];

    spim_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PRE_W(PRE_W), .LEN_W(LEN_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cfg_en(cfg_en), .cfg_mstr(cfg_mstr), .cfg_loop(cfg_loop),
        .cfg_rev(cfg_rev), .cfg_len(cfg_len), .cfg_pre(cfg_pre),
        .tx_word(tx_word), .tx_full(tx_full), .take(eng_take),
        .rx_done(eng_done), .rx_word(rx_word),
        .ev_rdy(ev_rdy), .ev_free(ev_free), .mask_bits(mask_bits), .irq(irq)
    );

    spim_clkdiv #(.PRE_W(PRE_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(eng_run), .pre(cfg_pre), .tick(tick)
    );

    spim_engine #(.DATA_W(DATA_W)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .tx_full(tx_full), .tx_word(tx_word),
        .cfg_rev(cfg_rev), .cfg_loop(cfg_loop), .cfg_len_m1(len_m1),
        .tick(tick), .miso(spi_miso),
        .take(eng_take), .done(eng_done), .busy(eng_busy), .run(eng_run),
        .rx_word(rx_word), .sck(spi_sck), .mosi(spi_mosi)
    );

endmodule

// File: rtl/spim_ctrl_chk.sv
module spim_ctrl_chk
    import spim_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sck,
    input logic       irq,
    input logic       busy,
    input logic       done,
    input logic       take,
    input logic       tx_full,
    input logic       ev_rdy,
    input logic       ev_free,
    input logic [1:0] mask_bits,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic [7:0] bus_addr,
    input logic       cfg_en,
    input logic       cfg_mstr
);

    assert_sck_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);

    assert_rdy_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ev_rdy);

    assert_free_low_while_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full |-> !ev_free);

    assert_take_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !tx_full);

    assert_zero_mask_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_bits == 2'b00) |-> !irq);

    assert_blocked_tx_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && (bus_addr == OFS_TX) && !(cfg_en && cfg_mstr) && !tx_full)
        |=> !tx_full);

endmodule

bind spim_ctrl spim_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .irq(irq),
    .busy(eng_busy), .done(eng_done), .take(eng_take), .tx_full(tx_full),
    .ev_rdy(ev_rdy), .ev_free(ev_free), .mask_bits(mask_bits),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .cfg_en(cfg_en), .cfg_mstr(cfg_mstr)
);

// File: tb/tb_spim_ctrl.sv
module tb_spim_ctrl;

    typedef struct packed {
        logic [3:0]  fld;
        logic        rev;
        logic        lp;
        logic [3:0]  pre;
        logic [31:0] tx;
        logic [31:0] pat;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{4'd7,  1'b1, 1'b0, 4'd0, 32'h0000_00A5, 32'h0000_003C},
        '{4'd7,  1'b0, 1'b0, 4'd1, 32'h0000_00A5, 32'h0000_003C},
        '{4'd0,  1'b1, 1'b1, 4'd0, 32'hDEAD_BEEF, 32'h0},
        '{4'd3,  1'b0, 1'b0, 4'd2, 32'hFFFF_FFF6, 32'h0000_0009},
        '{4'd15, 1'b1, 1'b0, 4'd0, 32'hFFFF_1234, 32'h0000_F0F0},
        '{4'd4,  1'b0, 1'b1, 4'd3, 32'h0000_0013, 32'h0},
        '{4'd1,  1'b1, 1'b0, 4'd0, 32'h0000_00F5, 32'h0000_0006}
    };

    localparam logic [7:0] A_MODE = 8'h20, A_EVT = 8'h24, A_MASK = 8'h28,
                           A_CMD  = 8'h2C, A_TX  = 8'h30, A_RX   = 8'h34;
    localparam logic [31:0] M_EN = 32'h0100_0000, M_MS = 32'h0200_0000,
                            M_REV = 32'h0400_0000, M_LOOP = 32'h4000_0000;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        spi_sck, spi_mosi, spi_miso = 1'b0, irq;

    int checks = 0, fails = 0, cyc = 0, nr = 0, nidx = 0;
    bit fin = 1'b0;
    logic [31:0] pat_cur = '0;
    logic        cap   [32];
    int          rise_t[32];

    spim_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .irq(irq)
    );

    always #10 clk = ~clk;
    always @(negedge clk) cyc++;

    always @(posedge spi_sck) begin
        if (nr < 32) begin
            cap[nr]    = spi_mosi;
            rise_t[nr] = cyc;
        end
        nr++;
    end

    always @(negedge spi_sck) begin
        nidx++;
        if (nidx < 32) spi_miso <= pat_cur[nidx];
    end

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=expired expected=finished");
            summary();
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_rdy(input string req);
        logic [31:0] v;
        bit ok = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            rd(A_EVT, v);
            if (v[9]) begin ok = 1'b1; break; end
        end
        check(req, {31'b0, ok}, 32'd1);
    endtask

    function automatic int len_of(input logic [3:0] f);
        if (f == 4'd0) return 32;
        if (f < 4'd4)  return 4;
        return int'(f) + 1;
    endfunction

    function automatic int slot(input int k, input int len, input logic rev);
        return rev ? (len - 1 - k) : k;
    endfunction

    initial begin
        logic [31:0] v, exp_rx, seq, exp_seq;
        int len;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_MODE, v); check("R1 mode", v, 32'h0);
        rd(A_EVT, v);  check("R1 event", v, 32'h100);
        wr(A_CMD, 32'hFFFF_FFFF);
        rd(A_CMD, v);  check("R1 command", v, 32'h0);
        check("R1 sck", {31'b0, spi_sck}, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // Vector table: R3 R4 R5 R6 R7
        for (int n = 0; n < NV; n++) begin
            vec_t t = VECS[n];
            len = len_of(t.fld);
            pat_cur = t.lp ? ~t.tx : t.pat;
            wr(A_MODE, M_EN | M_MS | (t.rev ? M_REV : 32'h0) | (t.lp ? M_LOOP : 32'h0)
                       | (32'(t.fld) << 20) | (32'(t.pre) << 16));
            wr(A_EVT, 32'hFFFF_FFFF);
            nr = 0; nidx = 0; spi_miso = pat_cur[0];
            wr(A_TX, t.tx);
            wait_rdy("R8 ready flag");
            rd(A_RX, v);
            exp_rx = '0; seq = '0; exp_seq = '0;
            for (int k = 0; k < len; k++) begin
                exp_rx[slot(k, len, t.rev)] = t.lp ? t.tx[slot(k, len, t.rev)] : t.pat[k];
                exp_seq[k] = t.tx[slot(k, len, t.rev)];
                seq[k] = cap[k];
            end
            check(t.lp ? "R7 R6 loopback data" : "R5 R6 received data", v, exp_rx);
            check("R3 pulse count", nr, len);
            check("R5 bit order on mosi", seq, exp_seq);
            check("R4 sck period", rise_t[1] - rise_t[0], 4 * (int'(t.pre) + 1));
        end

        // R2 disabled or non-master: writes ignored
        wr(A_EVT, 32'hFFFF_FFFF);
        wr(A_MODE, 32'h0070_0000);
        nr = 0;
        wr(A_TX, 32'h55);
        repeat (40) @(negedge clk);
        check("R2 no pulses when disabled", nr, 0);
        rd(A_EVT, v); check("R2 events unchanged", v, 32'h0);
        wr(A_MODE, M_EN | 32'h0070_0000);
        wr(A_TX, 32'h55);
        repeat (40) @(negedge clk);
        check("R2 no pulses when not master", nr, 0);

        // R9 held and dropped writes (loopback, 8 bits)
        wr(A_MODE, M_EN | M_MS | M_LOOP | 32'h0070_0000);
        wr(A_EVT, 32'hFFFF_FFFF);
        wr(A_TX, 32'h11);
        wr(A_TX, 32'h22);
        wr(A_TX, 32'h33);
        rd(A_EVT, v); check("R8 free flag low while held", v, 32'h0);
        wait_rdy("R9 first done");
        rd(A_RX, v); check("R9 first char", v, 32'h11);
        wr(A_EVT, 32'h200);
        wait_rdy("R9 second done");
        rd(A_RX, v); check("R9 held char sent, third dropped", v, 32'h22);
        repeat (60) @(negedge clk);
        rd(A_EVT, v); check("R9 no third exchange", v, 32'h300);

        // R10 write-one-to-clear and R11 interrupt
        wr(A_EVT, 32'h0);
        rd(A_EVT, v); check("R10 zero write keeps flags", v, 32'h300);
        wr(A_MASK, 32'h0);
        check("R11 zero mask", {31'b0, irq}, 32'h0);
        wr(A_MASK, 32'h200);
        check("R11 ready masked in", {31'b0, irq}, 32'h1);
        wr(A_EVT, 32'h200);
        rd(A_EVT, v); check("R10 clear ready only", v, 32'h100);
        check("R11 irq drops", {31'b0, irq}, 32'h0);
        wr(A_MASK, 32'h100);
        check("R11 free masked in", {31'b0, irq}, 32'h1);
        wr(A_EVT, 32'h100);
        rd(A_EVT, v); check("R10 clear free", v, 32'h0);
        check("R11 irq low after clear", {31'b0, irq}, 32'h0);

        fin = 1'b1;
        summary();
        $finish;
    end

endmodule